// File: doc/BRIEF.md
# Multi-master bus grant stage

This block lets several bus masters share one downstream request path. The number of masters is a power of two. A wrap-around index register picks which master owns the path. While the picked master keeps its cycle line low, the index steps by one on every clock. It stops stepping as soon as that master raises cycle, and it stays put until cycle falls again. An ongoing transfer therefore keeps its bus.

The picked master's request fields are cycle, lock, strobe, write enable, address, write data and byte select. They reach the downstream port through a single register stage. Downstream stall returns to the masters without any register in the path. Acknowledge, error and retry are sent only to the picked master. Read data is broadcast to every master. The one register stage gives short timing paths and costs one clock of request latency. Both classic and pipelined handshakes work, because the register holds its contents whenever stall is high.

Top module: `mbus_grant_stage`

## Requirements
- R1: While reset is high (synchronous, active-high), the grant index is set to master 0 and the downstream cycle and strobe outputs are cleared.
- R2: In every clock where the picked master's cycle input is low, the grant index advances by one. After the highest master (2^MST_BITS-1) it wraps to master 0.
- R3: In every clock where the picked master's cycle input is high, the grant index keeps its value.
- R4: When downstream stall is low, the downstream request outputs take the picked master's cycle, lock, strobe, write-enable, address, write-data and select values one clock later.
- R5: Bit g of the upstream stall vector equals the downstream stall input in the same cycle, where g is the granted master. Every other bit is 0.
- R6: While downstream stall is high, all downstream request outputs keep their values at the next clock. This rule takes precedence over R4 and R7.
- R7: When the picked master's cycle input is low and downstream stall is low, every downstream request output is 0 after the next clock.
- R8: Acknowledge, error and retry from downstream appear only on the granted master's bit of the matching upstream vector. Every other bit is 0.
- R9: The downstream read data drives the single upstream read-data bus unchanged, in the same cycle, for every master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_cyc | input | NM | Cycle line of each master |
| m_lock | input | NM | Lock line of each master |
| m_stb | input | NM | Strobe of each master |
| m_we | input | NM | Write enable of each master |
| m_adr | input | NM*ADR_W | Packed addresses, master i at bits [i*ADR_W +: ADR_W] |
| m_wdat | input | NM*DAT_W | Packed write data, master i at [i*DAT_W +: DAT_W] |
| m_sel | input | NM*SEL_W | Packed byte selects, master i at [i*SEL_W +: SEL_W] |
| m_rdat | output | DAT_W | Read data broadcast to all masters |
| m_ack | output | NM | Acknowledge, one bit per master |
| m_err | output | NM | Error, one bit per master |
| m_rty | output | NM | Retry, one bit per master |
| m_stall | output | NM | Stall, one bit per master |
| d_cyc | output | 1 | Registered downstream cycle |
| d_lock | output | 1 | Registered downstream lock |
| d_stb | output | 1 | Registered downstream strobe |
| d_we | output | 1 | Registered downstream write enable |
| d_adr | output | ADR_W | Registered downstream address |
| d_wdat | output | DAT_W | Registered downstream write data |
| d_sel | output | SEL_W | Registered downstream byte select |
| d_rdat | input | DAT_W | Downstream read data |
| d_ack | input | 1 | Downstream acknowledge |
| d_err | input | 1 | Downstream error |
| d_rty | input | 1 | Downstream retry |
| d_stall | input | 1 | Downstream stall |

## Verification
The grant index has no port of its own, so the bench has to see it indirectly. It holds downstream acknowledge high while every master is idle and watches which upstream acknowledge bit is set. That bit must move one place per clock and wrap from the top master back to master 0. The hardest case is a stall that arrives at the same moment as a grant change or a master dropping cycle. Stall then has to win over both the new request and the idle clear. Long randomized runs with independent cycle toggling and a stall rate near one third make these coincidences happen often. A behavioural model checks every output on every clock.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef struct packed {
    logic cyc;
    logic lock;
    logic stb;
    logic we;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{cyc: 1'b0, lock: 1'b0, stb: 1'b0, we: 1'b0};

endpackage

// File: rtl/mbus_grant_ctr.sv
module mbus_grant_ctr #(
  parameter int MST_BITS = 2,
  localparam int NM = 1 << MST_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NM-1:0]       m_cyc,
  output logic [MST_BITS-1:0] grant
);

  logic [MST_BITS-1:0] grant_q;
  logic                owner_busy;

  assign owner_busy = m_cyc[grant_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
    end else if (!owner_busy) begin
      grant_q <= grant_q + 1'b1;
    end
  end

  assign grant = grant_q;

endmodule

// File: rtl/mbus_req_mux.sv
module mbus_req_mux
  import mbus_pkg::*;
#(
  parameter int MST_BITS = 2,
  parameter int ADR_W    = 32,
  parameter int DAT_W    = 8,
  parameter int SEL_W    = 1,
  localparam int NM = 1 << MST_BITS
) (
  input  logic [MST_BITS-1:0] grant,
  input  logic [NM-1:0]       m_cyc,
  input  logic [NM-1:0]       m_lock,
  input  logic [NM-1:0]       m_stb,
  input  logic [NM-1:0]       m_we,
  input  logic [NM*ADR_W-1:0] m_adr,
  input  logic [NM*DAT_W-1:0] m_wdat,
  input  logic [NM*SEL_W-1:0] m_sel,
  output ctl_t                s_ctl,
  output logic [ADR_W-1:0]    s_adr,
  output logic [DAT_W-1:0]    s_wdat,
  output logic [SEL_W-1:0]    s_sel
);

  logic [ADR_W-1:0] adr_lane [NM];
  logic [DAT_W-1:0] dat_lane [NM];
  logic [SEL_W-1:0] sel_lane [NM];

  for (genvar i = 0; i < NM; i++) begin : g_lane
    assign adr_lane[i] = m_adr[i*ADR_W +: ADR_W];
    assign dat_lane[i] = m_wdat[i*DAT_W +: DAT_W];
    assign sel_lane[i] = m_sel[i*SEL_W +: SEL_W];
  end

  always_comb begin
    s_ctl  = CTL_IDLE;
    s_adr  = '0;
    s_wdat = '0;
    s_sel  = '0;
    if (m_cyc[grant]) begin
      s_ctl.cyc  = 1'b1;
      s_ctl.lock = m_lock[grant];
      s_ctl.stb  = m_stb[grant];
      s_ctl.we   = m_we[grant];
      s_adr      = adr_lane[grant];
      s_wdat     = dat_lane[grant];
      s_sel      = sel_lane[grant];
    end
  end

endmodule

// File: rtl/mbus_req_reg.sv
module mbus_req_reg
  import mbus_pkg::*;
#(
  parameter int ADR_W = 32,
  parameter int DAT_W = 8,
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  ctl_t             in_ctl,
  input  logic [ADR_W-1:0] in_adr,
  input  logic [DAT_W-1:0] in_wdat,
  input  logic [SEL_W-1:0] in_sel,
  output ctl_t             out_ctl,
  output logic [ADR_W-1:0] out_adr,
  output logic [DAT_W-1:0] out_wdat,
  output logic [SEL_W-1:0] out_sel
);

  ctl_t             ctl_q;
  logic [ADR_W-1:0] adr_q;
  logic [DAT_W-1:0] wdat_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= CTL_IDLE;
      adr_q  <= '0;
      wdat_q <= '0;
      sel_q  <= '0;
    end else if (!hold) begin
      ctl_q  <= in_ctl;
      adr_q  <= in_adr;
      wdat_q <= in_wdat;
      sel_q  <= in_sel;
    end
  end

  assign out_ctl  = ctl_q;
  assign out_adr  = adr_q;
  assign out_wdat = wdat_q;
  assign out_sel  = sel_q;

endmodule

// File: rtl/mbus_resp_route.sv
module mbus_resp_route #(
  parameter int MST_BITS = 2,
  parameter int DAT_W    = 8,
  localparam int NM = 1 << MST_BITS
) (
  input  logic [MST_BITS-1:0] grant,
  input  logic [DAT_W-1:0]    d_rdat,
  input  logic                d_ack,
  input  logic                d_err,
  input  logic                d_rty,
  input  logic                d_stall,
  output logic [DAT_W-1:0]    m_rdat,
  output logic [NM-1:0]       m_ack,
  output logic [NM-1:0]       m_err,
  output logic [NM-1:0]       m_rty,
  output logic [NM-1:0]       m_stall
);

  for (genvar i = 0; i < NM; i++) begin : g_route
    logic hit;
    assign hit        = (grant == MST_BITS'(i));
    assign m_ack[i]   = hit & d_ack;
    assign m_err[i]   = hit & d_err;
    assign m_rty[i]   = hit & d_rty;
    assign m_stall[i] = hit & d_stall;
  end

  assign m_rdat = d_rdat;

endmodule

// File: rtl/mbus_grant_stage.sv
module mbus_grant_stage
  import mbus_pkg::*;
#(
  parameter int MST_BITS = 2,
  parameter int ADR_W    = 32,
  parameter int DAT_W    = 8,
  parameter int SEL_W    = 1,
  localparam int NM = 1 << MST_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NM-1:0]       m_cyc,
  input  logic [NM-1:0]       m_lock,
  input  logic [NM-1:0]       m_stb,
  input  logic [NM-1:0]       m_we,
  input  logic [NM*ADR_W-1:0] m_adr,
  input  logic [NM*DAT_W-1:0] m_wdat,
  input  logic [NM*SEL_W-1:0] m_sel,
  output logic [DAT_W-1:0]    m_rdat,
  output logic [NM-1:0]       m_ack,
  output logic [NM-1:0]       m_err,
  output logic [NM-1:0]       m_rty,
  output logic [NM-1:0]       m_stall,
  output logic                d_cyc,
  output logic                d_lock,
  output logic                d_stb,
  output logic                d_we,
  output logic [ADR_W-1:0]    d_adr,
  output logic [DAT_W-1:0]    d_wdat,
  output logic [SEL_W-1:0]    d_sel,
  input  logic [DAT_W-1:0]    d_rdat,
  input  logic                d_ack,
  input  logic                d_err,
  input  logic                d_rty,
  input  logic                d_stall
);

  logic [MST_BITS-1:0] grant_idx;
  ctl_t                sel_ctl;
  logic [ADR_W-1:0]    sel_adr;
  logic [DAT_W-1:0]    sel_wdat;
  logic [SEL_W-1:0]    sel_sel;
  ctl_t                out_ctl;

  mbus_grant_ctr #(.MST_BITS(MST_BITS)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .m_cyc (m_cyc),
    .grant (grant_idx)
  );

  mbus_req_mux #(
    .MST_BITS(MST_BITS), .ADR_W(ADR_W), .DAT_W(DAT_W), .SEL_W(SEL_W)
  ) u_mux (
    .grant  (grant_idx),
    .m_cyc  (m_cyc),
    .m_lock (m_lock),
    .m_stb  (m_stb),
    .m_we   (m_we),
    .m_adr  (m_adr),
    .m_wdat (m_wdat),
    .m_sel  (m_sel),
    .s_ctl  (sel_ctl),
    .s_adr  (sel_adr),
    .s_wdat (sel_wdat),
    .s_sel  (sel_sel)
  );

  mbus_req_reg #(.ADR_W(ADR_W), .DAT_W(DAT_W), .SEL_W(SEL_W)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .hold     (d_stall),
    .in_ctl   (sel_ctl),
    .in_adr   (sel_adr),
    .in_wdat  (sel_wdat),
    .in_sel   (sel_sel),
    .out_ctl  (out_ctl),
    .out_adr  (d_adr),
    .out_wdat (d_wdat),
    .out_sel  (d_sel)
  );

  assign d_cyc  = out_ctl.cyc;
  assign d_lock = out_ctl.lock;
  assign d_stb  = out_ctl.stb;
  assign d_we   = out_ctl.we;

  mbus_resp_route #(.MST_BITS(MST_BITS), .DAT_W(DAT_W)) u_resp (
    .grant   (grant_idx),
    .d_rdat  (d_rdat),
    .d_ack   (d_ack),
    .d_err   (d_err),
    .d_rty   (d_rty),
    .d_stall (d_stall),
    .m_rdat  (m_rdat),
    .m_ack   (m_ack),
    .m_err   (m_err),
    .m_rty   (m_rty),
    .m_stall (m_stall)
  );

endmodule

// File: rtl/mbus_grant_checker.sv
module mbus_grant_checker #(
  parameter int MST_BITS = 2,
  parameter int ADR_W    = 32,
  parameter int DAT_W    = 8,
  parameter int SEL_W    = 1,
  localparam int NM = 1 << MST_BITS
) (
  input logic                clk,
  input logic                rst,
  input logic [MST_BITS-1:0] grant,
  input logic [NM-1:0]       m_cyc,
  input logic [NM-1:0]       m_ack,
  input logic [NM-1:0]       m_err,
  input logic [NM-1:0]       m_rty,
  input logic [NM-1:0]       m_stall,
  input logic                d_cyc,
  input logic                d_lock,
  input logic                d_stb,
  input logic                d_we,
  input logic [ADR_W-1:0]    d_adr,
  input logic [DAT_W-1:0]    d_wdat,
  input logic [SEL_W-1:0]    d_sel,
  input logic                d_ack,
  input logic                d_stall
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (!d_cyc && !d_stb && grant == '0)); // R1

  AST_GRANT_STEP: assert property (@(posedge clk) disable iff (rst)
    !m_cyc[grant] |=> grant == MST_BITS'($past(grant) + 1'b1)); // R2

  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (rst)
    m_cyc[grant] |=> $stable(grant)); // R3

  AST_STALL_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
    $countones(m_stall) <= 1 && m_stall[grant] == d_stall); // R5

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    d_stall |=> $stable({d_cyc, d_lock, d_stb, d_we, d_adr, d_wdat, d_sel})); // R6

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!m_cyc[grant] && !d_stall) |=> (!d_cyc && !d_stb && !d_lock && !d_we)); // R7

  AST_RESP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(m_ack) && $onehot0(m_err) && $onehot0(m_rty)); // R8

  AST_ACK_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !d_ack |-> m_ack == '0); // R8

endmodule

bind mbus_grant_stage mbus_grant_checker #(
  .MST_BITS(MST_BITS), .ADR_W(ADR_W), .DAT_W(DAT_W), .SEL_W(SEL_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .grant   (grant_idx),
  .m_cyc   (m_cyc),
  .m_ack   (m_ack),
  .m_err   (m_err),
  .m_rty   (m_rty),
  .m_stall (m_stall),
  .d_cyc   (d_cyc),
  .d_lock  (d_lock),
  .d_stb   (d_stb),
  .d_we    (d_we),
  .d_adr   (d_adr),
  .d_wdat  (d_wdat),
  .d_sel   (d_sel),
  .d_ack   (d_ack),
  .d_stall (d_stall)
);

// File: tb/test_mbus_grant_stage.sv
module test_mbus_grant_stage;

  localparam int MST_BITS = 2;
  localparam int ADR_W    = 32;
  localparam int DAT_W    = 8;
  localparam int SEL_W    = 1;
  localparam int NM       = 1 << MST_BITS;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [NM-1:0]       m_cyc = '0, m_lock = '0, m_stb = '0, m_we = '0;
  logic [NM*ADR_W-1:0] m_adr = '0;
  logic [NM*DAT_W-1:0] m_wdat = '0;
  logic [NM*SEL_W-1:0] m_sel = '0;
  logic [DAT_W-1:0]    m_rdat;
  logic [NM-1:0]       m_ack, m_err, m_rty, m_stall;
  logic                d_cyc, d_lock, d_stb, d_we;
  logic [ADR_W-1:0]    d_adr;
  logic [DAT_W-1:0]    d_wdat;
  logic [SEL_W-1:0]    d_sel;
  logic [DAT_W-1:0]    d_rdat = '0;
  logic                d_ack = 1'b0, d_err = 1'b0, d_rty = 1'b0, d_stall = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mbus_grant_stage #(
    .MST_BITS(MST_BITS), .ADR_W(ADR_W), .DAT_W(DAT_W), .SEL_W(SEL_W)
  ) i_mbus_grant_stage (
    .clk(clk), .rst(rst),
    .m_cyc(m_cyc), .m_lock(m_lock), .m_stb(m_stb), .m_we(m_we),
    .m_adr(m_adr), .m_wdat(m_wdat), .m_sel(m_sel),
    .m_rdat(m_rdat), .m_ack(m_ack), .m_err(m_err), .m_rty(m_rty), .m_stall(m_stall),
    .d_cyc(d_cyc), .d_lock(d_lock), .d_stb(d_stb), .d_we(d_we),
    .d_adr(d_adr), .d_wdat(d_wdat), .d_sel(d_sel),
    .d_rdat(d_rdat), .d_ack(d_ack), .d_err(d_err), .d_rty(d_rty), .d_stall(d_stall)
  );

  // behavioural reference state
  int               ref_g = 0;
  logic [3:0]       ref_ctl = '0;   // {cyc, lock, stb, we}
  logic [ADR_W-1:0] ref_adr = '0;
  logic [DAT_W-1:0] ref_wdat = '0;
  logic [SEL_W-1:0] ref_sel = '0;
  string            req_tag = "R1";

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst) begin
      ref_g = 0; ref_ctl = '0; ref_adr = '0; ref_wdat = '0; ref_sel = '0;
      req_tag = "R1";
    end else begin
      if (d_stall) begin
        req_tag = "R6";
      end else if (m_cyc[ref_g]) begin
        ref_ctl  = {1'b1, m_lock[ref_g], m_stb[ref_g], m_we[ref_g]};
        ref_adr  = m_adr[ref_g*ADR_W +: ADR_W];
        ref_wdat = m_wdat[ref_g*DAT_W +: DAT_W];
        ref_sel  = m_sel[ref_g*SEL_W +: SEL_W];
        req_tag  = "R4";
      end else begin
        ref_ctl = '0; ref_adr = '0; ref_wdat = '0; ref_sel = '0;
        req_tag = "R7";
      end
      if (!m_cyc[ref_g]) ref_g = (ref_g + 1) % NM;
    end
    @(negedge clk);
    check({req_tag, " request control"}, 64'({d_cyc, d_lock, d_stb, d_we}), 64'(ref_ctl));
    check({req_tag, " request address"}, 64'(d_adr), 64'(ref_adr));
    check({req_tag, " request data"}, 64'({d_wdat, d_sel}), 64'({ref_wdat, ref_sel}));
    check("R5 stall routing", 64'(m_stall), 64'(d_stall) << ref_g);
    check("R8 ack routing", 64'(m_ack), 64'(d_ack) << ref_g);
    check("R8 err routing", 64'(m_err), 64'(d_err) << ref_g);
    check("R8 rty routing", 64'(m_rty), 64'(d_rty) << ref_g);
    check("R9 read data broadcast", 64'(m_rdat), 64'(d_rdat));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [NM-1:0] prev_ack;
    // reset with ack high: grant index 0 must be visible on the ack vector
    d_ack = 1'b1;
    repeat (3) tick();
    check("R1 reset cycle low", 64'({d_cyc, d_stb}), 64'(0));
    check("R1 reset grant index 0", 64'(m_ack), 64'(1));
    rst = 1'b0;

    // all idle: ack bit rotates one place per clock and wraps
    tick();
    prev_ack = m_ack;
    for (int k = 0; k < 3 * NM; k++) begin
      tick();
      check("R2 grant steps and wraps", 64'(m_ack),
            64'({prev_ack[NM-2:0], prev_ack[NM-1]}));
      prev_ack = m_ack;
    end

    // master 2 claims the bus and keeps it
    m_cyc[2] = 1'b1; m_stb[2] = 1'b1; m_we[2] = 1'b1;
    m_adr[2*ADR_W +: ADR_W] = 32'hA5A5_0042;
    m_wdat[2*DAT_W +: DAT_W] = 8'h3C;
    m_sel[2*SEL_W +: SEL_W] = 1'b1;
    for (int k = 0; k < NM + 1; k++) tick();
    for (int k = 0; k < 6; k++) begin
      tick();
      check("R3 grant held while cycle high", 64'(m_ack), 64'(4));
    end
    check("R4 granted address forwarded", 64'(d_adr), 64'(32'hA5A5_0042));

    // stall freezes the register while the master changes its request
    d_stall = 1'b1;
    m_adr[2*ADR_W +: ADR_W] = 32'h0000_1111;
    tick();
    tick();
    check("R6 address frozen under stall", 64'(d_adr), 64'(32'hA5A5_0042));
    m_cyc[2] = 1'b0; m_stb[2] = 1'b0;
    tick();
    check("R6 cycle frozen under stall", 64'(d_cyc), 64'(1));
    d_stall = 1'b0;
    tick();
    tick();
    check("R7 idle request cleared", 64'({d_cyc, d_stb}), 64'(0));

    // randomized traffic
    d_ack = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      for (int i = 0; i < NM; i++) begin
        if ($urandom_range(0, 5) == 0) m_cyc[i] = ~m_cyc[i];
        m_stb[i]  = m_cyc[i] & $urandom_range(0, 1);
        m_lock[i] = $urandom_range(0, 1);
        m_we[i]   = $urandom_range(0, 1);
        m_adr[i*ADR_W +: ADR_W]  = $urandom;
        m_wdat[i*DAT_W +: DAT_W] = DAT_W'($urandom);
        m_sel[i*SEL_W +: SEL_W]  = SEL_W'($urandom);
      end
      d_stall = ($urandom_range(0, 2) == 0);
      d_ack   = $urandom_range(0, 1);
      d_err   = ($urandom_range(0, 7) == 0);
      d_rty   = ($urandom_range(0, 7) == 0);
      d_rdat  = DAT_W'($urandom);
      tick();
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule